// File: doc/BRIEF.md
# Key and Power Button Controller with Auto-Repeat

This block watches a small group of application keys and a single power button. Each key is synchronised and debounced. The block then reports press, release and auto-repeat events through sticky flags in a byte-wide register file. The power button is timed by its own hold counter. A hold that begins while the system is off switches power on. A hold that begins while the system is on first raises a long-press flag and later forces power off. All timing advances on a one-millisecond enable pulse, so the block runs from any clock faster than that pulse.

Software sets the interrupt enables, the key-input enable and the one-hot repeat period through the register port. It polls or takes the interrupt, and it clears a flag by writing zero to that flag's bit. A separate non-maskable request line follows the long-press flag when it is enabled.

Top module: `keysw_ctrl`

## Requirements
- R1: After reset, the control register reads 0x20, the repeat register reads 0x01 and the status register reads 0x00; sys_pwr_o is 1 and irq_o and nmi_o are 0.
- R2: The register map is: address 0 control (bit0 key enable, bit1 press irq enable, bit2 repeat irq enable, bit3 long-press irq enable, bit4 nmi enable, bit5 release irq enable, bits 7:6 read 0); address 1 repeat select (8 bits, reads back as written); address 2 status (bit0 press, bit1 repeat, bit2 long-press, bit3 release); address 3 reads 0.
- R3: A key input passes a two-flop synchroniser, and its debounced level changes only after the synchronised input has differed from it for 20 consecutive ticks. A shorter pulse produces no event.
- R4: While the key enable is 1, a debounced press of any key sets the press flag and a debounced release sets the release flag.
- R5: While a key is held and the key enable is 1, the repeat flag is set after one repeat period of ticks and again every period until release. The period is 100 + 50*i ms, where i is the lowest set bit of the repeat register; a value of 0 selects 100 ms.
- R6: While the key enable is 0, no key press, release or repeat sets a flag, and repeat timing restarts from zero.
- R7: Writing the status register clears each flag whose written bit is 0 and leaves flags whose bit is 1. A flag set in the same cycle wins.
- R8: irq_o is high when any status flag and its enable are both 1. nmi_o is high when the long-press flag and the nmi enable are both 1.
- R9: A power-button hold that starts while the system is powered sets the long-press flag once, after 2000 ticks, and not again during that hold.
- R10: A power-button hold that starts while the system is powered drives sys_pwr_o to 0 after 4000 ticks.
- R11: A power-button hold that starts while the system is off drives sys_pwr_o to 1 after 500 ticks. Continuing that hold neither sets the long-press flag nor switches power off.
- R12: All debounce, repeat and hold counters advance only in cycles where tick_ms_i is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_ms_i | input | 1 | One-cycle millisecond enable |
| keys_i | input | NUM_KEYS | Raw application key levels, 1 = pressed |
| pwr_btn_i | input | 1 | Raw power button level, 1 = pressed |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for reg_addr_i (combinational) |
| sys_pwr_o | output | 1 | System power enable |
| irq_o | output | 1 | Maskable interrupt request |
| nmi_o | output | 1 | Non-maskable interrupt request |

## Verification
Most internal state shows up at the ports within a period of ticks. A debounce or repeat counter that is off by one moves the status register's flag edge by one cycle. A wrong power-mode latch shows as sys_pwr_o toggling at the wrong hold length, or as the long-press flag and nmi_o rising during a power-on hold. The bench model predicts the register read data, sys_pwr_o and irq_o every clock, so such a slip is caught in the first cycle where the outputs disagree rather than at a later summary read.

// File: rtl/keysw_pkg.sv
package keysw_pkg;

  typedef enum logic [1:0] {
    ADDR_CTRL   = 2'd0,
    ADDR_RPT    = 2'd1,
    ADDR_STATUS = 2'd2,
    ADDR_NONE   = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic off_ie;
    logic nmi_en;
    logic pwr_ie;
    logic rpt_ie;
    logic on_ie;
    logic key_en;
  } ctrl_t;

  typedef struct packed {
    logic off;
    logic pwr;
    logic rpt;
    logic on;
  } flags_t;

  localparam ctrl_t      CTRL_RST = ctrl_t'(6'h20);
  localparam logic [7:0] RPT_RST  = 8'h01;

endpackage

// File: rtl/keysw_debounce.sv
module keysw_debounce #(
  parameter int unsigned DB_MS = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic raw_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned CW = $clog2(DB_MS + 1);

  logic          s1_q, s2_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q    <= 1'b0;
      s2_q    <= 1'b0;
      cnt_q   <= '0;
      level_o <= 1'b0;
      rise_o  <= 1'b0;
      fall_o  <= 1'b0;
    end else begin
      s1_q   <= raw_i;
      s2_q   <= s1_q;
      rise_o <= 1'b0;
      fall_o <= 1'b0;
      if (s2_q == level_o) begin
        cnt_q <= '0;
      end else if (tick_i) begin
        if (cnt_q == CW'(DB_MS - 1)) begin
          cnt_q   <= '0;
          level_o <= s2_q;
          rise_o  <= s2_q;
          fall_o  <= ~s2_q;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/keysw_repeat.sv
module keysw_repeat #(
  parameter int unsigned PW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          run_i,
  input  logic [PW-1:0] period_i,
  output logic          fire_o
);
  logic [PW-1:0] cnt_q;
  logic          wrap;

  assign wrap   = (cnt_q == period_i - 1'b1);
  assign fire_o = run_i & tick_i & wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (tick_i) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/keysw_pwr_btn.sv
module keysw_pwr_btn #(
  parameter int unsigned ON_MS   = 500,
  parameter int unsigned FLAG_MS = 2000,
  parameter int unsigned OFF_MS  = 4000,
  parameter bit          PWR_RST = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic btn_i,
  output logic sys_pwr_o,
  output logic long_o,
  output logic held_o
);
  localparam int unsigned CW = $clog2(OFF_MS + 1);

  logic          s1_q, s2_q, from_on_q;
  logic [CW-1:0] cnt_q;
  logic          hit_on, hit_flag, hit_off;

  assign held_o   = s2_q;
  assign hit_on   = s2_q & tick_i & (cnt_q == CW'(ON_MS - 1));
  assign hit_flag = s2_q & tick_i & (cnt_q == CW'(FLAG_MS - 1));
  assign hit_off  = s2_q & tick_i & (cnt_q == CW'(OFF_MS - 1));
  assign long_o   = hit_flag & from_on_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q      <= 1'b0;
      s2_q      <= 1'b0;
      cnt_q     <= '0;
      from_on_q <= PWR_RST;
      sys_pwr_o <= PWR_RST;
    end else begin
      s1_q <= btn_i;
      s2_q <= s1_q;
      // power state seen at press start fixes the meaning of the whole hold
      if (!s2_q) from_on_q <= sys_pwr_o;
      if (!s2_q) cnt_q <= '0;
      else if (tick_i && cnt_q != CW'(OFF_MS)) cnt_q <= cnt_q + 1'b1;
      if (hit_on && !from_on_q)     sys_pwr_o <= 1'b1;
      else if (hit_off && from_on_q) sys_pwr_o <= 1'b0;
    end
  end
endmodule

// File: rtl/keysw_ctrl.sv
module keysw_ctrl
  import keysw_pkg::*;
#(
  parameter int unsigned NUM_KEYS     = 4,
  parameter int unsigned DEBOUNCE_MS  = 20,
  parameter int unsigned RPT_BASE_MS  = 100,
  parameter int unsigned RPT_STEP_MS  = 50,
  parameter int unsigned PWR_ON_MS    = 500,
  parameter int unsigned PWR_FLAG_MS  = 2000,
  parameter int unsigned PWR_OFF_MS   = 4000,
  parameter bit          PWR_AT_RESET = 1'b1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_ms_i,
  input  logic [NUM_KEYS-1:0] keys_i,
  input  logic                pwr_btn_i,
  input  logic                reg_wr_i,
  input  logic [1:0]          reg_addr_i,
  input  logic [7:0]          reg_wdata_i,
  output logic [7:0]          reg_rdata_o,
  output logic                sys_pwr_o,
  output logic                irq_o,
  output logic                nmi_o
);
  localparam int unsigned RPT_MAX_MS = RPT_BASE_MS + 7 * RPT_STEP_MS;
  localparam int unsigned RPT_W      = $clog2(RPT_MAX_MS + 1);

  ctrl_t               ctrl_q;
  logic [7:0]          rpt_sel_q;
  flags_t              flag_q, flag_set;
  logic                key_en, pwr_long, btn_held;
  logic [RPT_W-1:0]    period;
  logic [NUM_KEYS-1:0] lvl, rise, fall, fire;

  assign key_en = ctrl_q.key_en;

  // lowest set select bit wins; empty select falls back to the base period
  always_comb begin
    period = RPT_W'(RPT_BASE_MS);
    for (int i = 7; i >= 0; i--)
      if (rpt_sel_q[i]) period = RPT_W'(RPT_BASE_MS + 32'(i) * RPT_STEP_MS);
  end

  for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
    keysw_debounce #(.DB_MS(DEBOUNCE_MS)) u_db (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (tick_ms_i),
      .raw_i  (keys_i[k]),
      .level_o(lvl[k]),
      .rise_o (rise[k]),
      .fall_o (fall[k])
    );
    keysw_repeat #(.PW(RPT_W)) u_rpt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (tick_ms_i),
      .run_i   (lvl[k] & key_en),
      .period_i(period),
      .fire_o  (fire[k])
    );
  end

  keysw_pwr_btn #(
    .ON_MS  (PWR_ON_MS),
    .FLAG_MS(PWR_FLAG_MS),
    .OFF_MS (PWR_OFF_MS),
    .PWR_RST(PWR_AT_RESET)
  ) u_pwr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_ms_i),
    .btn_i    (pwr_btn_i),
    .sys_pwr_o(sys_pwr_o),
    .long_o   (pwr_long),
    .held_o   (btn_held)
  );

  always_comb begin
    flag_set.on  = key_en & (|rise);
    flag_set.off = key_en & (|fall);
    flag_set.rpt = |fire;
    flag_set.pwr = pwr_long;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= CTRL_RST;
      rpt_sel_q <= RPT_RST;
      flag_q    <= '0;
    end else begin
      if (reg_wr_i && reg_addr_i == ADDR_CTRL) ctrl_q    <= ctrl_t'(reg_wdata_i[5:0]);
      if (reg_wr_i && reg_addr_i == ADDR_RPT)  rpt_sel_q <= reg_wdata_i;
      if (reg_wr_i && reg_addr_i == ADDR_STATUS)
        flag_q <= (flag_q & flags_t'(reg_wdata_i[3:0])) | flag_set;
      else
        flag_q <= flag_q | flag_set;
    end
  end

  always_comb begin
    unique case (reg_addr_i)
      ADDR_CTRL:   reg_rdata_o = {2'b00, ctrl_q};
      ADDR_RPT:    reg_rdata_o = rpt_sel_q;
      ADDR_STATUS: reg_rdata_o = {4'h0, flag_q};
      default:     reg_rdata_o = 8'h00;
    endcase
  end

  assign irq_o = (flag_q.on  & ctrl_q.on_ie)  | (flag_q.rpt & ctrl_q.rpt_ie) |
                 (flag_q.pwr & ctrl_q.pwr_ie) | (flag_q.off & ctrl_q.off_ie);
  assign nmi_o = flag_q.pwr & ctrl_q.nmi_en;

endmodule

// File: rtl/keysw_ctrl_chk.sv
module keysw_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_ms_i,
  input logic       reg_wr_i,
  input logic       sys_pwr_o,
  input logic       irq_o,
  input logic       nmi_o,
  input logic [3:0] flags_i,
  input logic       key_en_i,
  input logic       btn_held_i
);
  assert_irq_needs_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (flags_i != 4'h0));

  assert_nmi_needs_long_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_o |-> flags_i[2]);

  assert_flags_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_wr_i |=> ((flags_i & $past(flags_i)) == $past(flags_i)));

  assert_key_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !key_en_i |=> ((flags_i & ~$past(flags_i) & 4'b1011) == 4'h0));

  assert_off_by_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sys_pwr_o) |-> $past(btn_held_i));

  assert_on_by_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_pwr_o) |-> $past(btn_held_i));

  assert_pwr_on_tick_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_ms_i |=> $stable(sys_pwr_o));
endmodule

bind keysw_ctrl keysw_ctrl_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_ms_i (tick_ms_i),
  .reg_wr_i  (reg_wr_i),
  .sys_pwr_o (sys_pwr_o),
  .irq_o     (irq_o),
  .nmi_o     (nmi_o),
  .flags_i   (flag_q),
  .key_en_i  (key_en),
  .btn_held_i(btn_held)
);

// File: tb/keysw_ctrl_test.sv
module keysw_ctrl_test;
  localparam int NK = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b1;
  logic [NK-1:0] keys = '0;
  logic          btn = 1'b0;
  logic          wr = 1'b0;
  logic [1:0]    addr = 2'd0;
  logic [7:0]    wdata = 8'h00;
  logic [7:0]    rdata;
  logic          sys_pwr, irq, nmi;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  keysw_ctrl #(.NUM_KEYS(NK)) uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_ms_i(tick), .keys_i(keys),
    .pwr_btn_i(btn), .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .sys_pwr_o(sys_pwr), .irq_o(irq), .nmi_o(nmi)
  );

  // ---------------- behavioural reference model ----------------
  int m_s1[NK], m_s2[NK], m_db[NK], m_dc[NK], m_rise[NK], m_fall[NK], m_rc[NK];
  int m_ctrl, m_rpt, m_flag;
  int m_b1, m_b2, m_pc, m_from_on, m_pwr;

  function automatic int m_period(int sel);
    int p = 100;
    for (int i = 7; i >= 0; i--) if ((sel >> i) & 1) p = 100 + 50 * i;
    return p;
  endfunction

  function automatic int m_read(int a);
    case (a)
      0: return m_ctrl;
      1: return m_rpt;
      2: return m_flag;
      default: return 0;
    endcase
  endfunction

  function automatic int m_irq();
    int f = m_flag, c = m_ctrl;
    return (((f & 1) && (c & 2)) || ((f & 2) && (c & 4)) ||
            ((f & 4) && (c & 8)) || ((f & 8) && (c & 32))) ? 1 : 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NK; k++) begin
        m_s1[k] = 0; m_s2[k] = 0; m_db[k] = 0; m_dc[k] = 0;
        m_rise[k] = 0; m_fall[k] = 0; m_rc[k] = 0;
      end
      m_ctrl = 32'h20; m_rpt = 1; m_flag = 0;
      m_b1 = 0; m_b2 = 0; m_pc = 0; m_from_on = 1; m_pwr = 1;
    end else begin
      int per, set, en, t, npwr;
      per = m_period(m_rpt);
      en  = m_ctrl & 1;
      t   = tick ? 1 : 0;
      set = 0;
      for (int k = 0; k < NK; k++) begin
        if (en && m_rise[k]) set |= 1;
        if (en && m_fall[k]) set |= 8;
        if (en && m_db[k] && t && m_rc[k] == per - 1) set |= 2;
      end
      if (m_b2 && t && m_pc == 1999 && m_from_on) set |= 4;
      npwr = m_pwr;
      if (m_b2 && t && m_pc == 499 && !m_from_on) npwr = 1;
      else if (m_b2 && t && m_pc == 3999 && m_from_on) npwr = 0;
      if (wr && addr == 2) m_flag = (m_flag & wdata[3:0]) | set;
      else m_flag = m_flag | set;
      if (wr && addr == 0) m_ctrl = wdata & 8'h3F;
      if (wr && addr == 1) m_rpt = wdata;
      for (int k = 0; k < NK; k++) begin
        if (!m_db[k] || !en) m_rc[k] = 0;
        else if (t) m_rc[k] = (m_rc[k] == per - 1) ? 0 : m_rc[k] + 1;
        m_rise[k] = 0; m_fall[k] = 0;
        if (m_s2[k] == m_db[k]) m_dc[k] = 0;
        else if (t) begin
          if (m_dc[k] == 19) begin
            m_dc[k] = 0; m_db[k] = m_s2[k];
            m_rise[k] = m_s2[k]; m_fall[k] = !m_s2[k];
          end else m_dc[k]++;
        end
        m_s2[k] = m_s1[k]; m_s1[k] = keys[k];
      end
      if (!m_b2) m_from_on = m_pwr;
      if (!m_b2) m_pc = 0;
      else if (t && m_pc != 4000) m_pc++;
      m_pwr = npwr;
      m_b2 = m_b1; m_b1 = btn;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      chk("R2 read data vs model", rdata, m_read(addr));
      chk("R10/R11 power vs model", sys_pwr, m_pwr);
      chk("R8 irq vs model", irq, m_irq());
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input int a, input int d);
    @(negedge clk);
    wr = 1'b1; addr = 2'(a); wdata = 8'(d);
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_chk(input int a, input int exp, input string tag);
    @(negedge clk);
    addr = 2'(a);
    @(posedge clk);
    #2 chk(tag, rdata, exp);
  endtask

  task automatic port_chk(input string tag, input int act, input int exp);
    @(posedge clk);
    #3 chk(tag, act, exp);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    // R1 reset state
    rd_chk(0, 8'h20, "R1 ctrl reset");
    rd_chk(1, 8'h01, "R1 repeat reset");
    rd_chk(2, 8'h00, "R1 status reset");
    port_chk("R1 power reset", sys_pwr, 1);
    port_chk("R1 nmi reset", nmi, 0);

    wr_reg(0, 8'h3F);
    // R3 short glitch rejected
    @(negedge clk) keys[3] = 1'b1;
    wait_cyc(15);
    keys[3] = 1'b0;
    wait_cyc(60);
    rd_chk(2, 8'h00, "R3 glitch ignored");

    // R4/R5 press, repeat at 100 ms, release
    keys[0] = 1'b1;
    wait_cyc(60);
    rd_chk(2, 8'h01, "R4 press flag");
    wait_cyc(290);
    rd_chk(2, 8'h03, "R5 repeat flag 100ms");
    keys[0] = 1'b0;
    wait_cyc(40);
    rd_chk(2, 8'h0B, "R4 release flag");
    port_chk("R8 irq with enables", irq, 1);

    // R7 clearing
    wr_reg(2, 8'hFF);
    rd_chk(2, 8'h0B, "R7 write ones keeps");
    wr_reg(2, 8'h08);
    rd_chk(2, 8'h08, "R7 partial clear");
    wr_reg(2, 8'h00);
    rd_chk(2, 8'h00, "R7 full clear");
    port_chk("R8 irq idle", irq, 0);

    // R5 longest period 450 ms
    wr_reg(1, 8'h80);
    @(negedge clk) keys[1] = 1'b1;
    wait_cyc(400);
    rd_chk(2, 8'h01, "R5 no repeat before 450");
    wait_cyc(150);
    rd_chk(2, 8'h03, "R5 repeat after 450");
    keys[1] = 1'b0;
    wait_cyc(40);
    wr_reg(2, 0);

    // R5 lowest set bit wins: 0x06 -> 150 ms
    wr_reg(1, 8'h06);
    @(negedge clk) keys[0] = 1'b1;
    wait_cyc(160);
    rd_chk(2, 8'h01, "R5 no repeat before 150");
    wait_cyc(40);
    rd_chk(2, 8'h03, "R5 repeat after 150");
    keys[0] = 1'b0;
    wait_cyc(40);
    wr_reg(2, 0);

    // R5 empty select -> 100 ms
    wr_reg(1, 8'h00);
    @(negedge clk) keys[2] = 1'b1;
    wait_cyc(115);
    rd_chk(2, 8'h01, "R5 empty select early");
    wait_cyc(30);
    rd_chk(2, 8'h03, "R5 empty select 100ms");
    keys[2] = 1'b0;
    wait_cyc(40);
    wr_reg(2, 0);
    wr_reg(1, 8'h01);

    // R6 key enable off
    wr_reg(0, 8'h3E);
    @(negedge clk) keys[2] = 1'b1;
    wait_cyc(300);
    keys[2] = 1'b0;
    wait_cyc(40);
    rd_chk(2, 8'h00, "R6 suppressed");
    port_chk("R6 irq quiet", irq, 0);
    wr_reg(0, 8'h3F);

    // R12 no ticks, no progress
    @(negedge clk) begin tick = 1'b0; keys[0] = 1'b1; end
    wait_cyc(100);
    rd_chk(2, 8'h00, "R12 frozen without tick");
    @(negedge clk) tick = 1'b1;
    wait_cyc(40);
    rd_chk(2, 8'h01, "R12 resumes with tick");
    keys[0] = 1'b0;
    wait_cyc(40);
    wr_reg(2, 0);

    // R9/R10 hold while powered
    @(negedge clk) btn = 1'b1;
    wait_cyc(2100);
    rd_chk(2, 8'h04, "R9 long-press flag");
    port_chk("R8 nmi follows flag", nmi, 1);
    port_chk("R9 still powered", sys_pwr, 1);
    wr_reg(2, 0);
    port_chk("R8 nmi cleared", nmi, 0);
    wait_cyc(2000);
    port_chk("R10 power off", sys_pwr, 0);
    rd_chk(2, 8'h00, "R9 once per press");
    @(negedge clk) btn = 1'b0;
    wait_cyc(10);

    // R11 hold while off
    @(negedge clk) btn = 1'b1;
    wait_cyc(450);
    port_chk("R11 not yet on", sys_pwr, 0);
    wait_cyc(150);
    port_chk("R11 power on", sys_pwr, 1);
    wait_cyc(3700);
    port_chk("R11 stays on", sys_pwr, 1);
    rd_chk(2, 8'h00, "R11 no long-press flag");
    @(negedge clk) btn = 1'b0;
    wait_cyc(10);

    // R8 masking
    @(negedge clk) keys[1] = 1'b1;
    wait_cyc(40);
    keys[1] = 1'b0;
    wr_reg(0, 8'h01);
    port_chk("R8 masked", irq, 0);
    wr_reg(0, 8'h13);
    port_chk("R8 press enabled", irq, 1);
    port_chk("R8 nmi without flag", nmi, 0);
    wait_cyc(40);

    // R2 map
    wr_reg(0, 8'hFF);
    rd_chk(0, 8'h3F, "R2 ctrl width");
    wr_reg(1, 8'hA4);
    rd_chk(1, 8'hA4, "R2 repeat readback");
    rd_chk(3, 8'h00, "R2 unused address");

    wait_cyc(5);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule